// File: doc/BRIEF.md
# Chase Test-Vector Single-Symbol Error Decoder

This block is the processing stage of a soft-input decoder for a Reed-Solomon component code over GF(32) (31 symbols of 5 bits). It is given the two base syndromes of a received hard-decision word, the locations of its least reliable bits, and the reliability magnitudes of every bit. From these it forms a family of test vectors, each of which inverts some combination of the weakest bits. Each vector is decoded for a single symbol error in closed form, and then scored. The best-scoring vector becomes the decided word, and the next few become competitors.

One test vector is handled per clock. The syndromes and bit locations are captured when a run starts. The reliability word must stay stable until the run ends. When the run ends, a one-cycle done strobe marks the outputs as valid. A reduced mode halves the number of test vectors and keeps a single competitor.

Top module: `tvsed_top`

## Requirements
- R1: After reset, busy_o, done_o, dec_valid_o and every comp_valid_o bit are low.
- R2: Test vector i (i = 0 .. count-1) inverts weak bit k exactly when bit k of i is 1. Weak bit k is entry k of lrb_sym_i/lrb_bit_i, where k occupies bits [5k+4:5k] of lrb_sym_i and bits [3k+2:3k] of lrb_bit_i. Inverting bit b of symbol j XORs 2^b into syndrome S0 and alpha^(j+b) into S1. The field is GF(32) with x^5+x^2+1, alpha = 2, and symbol j carries the locator alpha^j.
- R3: A vector whose two syndromes are both zero needs no correction: fix = 0, position 0, value 0. If both syndromes are nonzero, the value is S0 and the position is the j with S1 = S0·alpha^j (fix = 1). If exactly one syndrome is zero, the vector is excluded from selection.
- R4: The metric of a vector is the sum of the reliabilities of all bits where the corrected vector differs from the hard decision. A weak bit that is both inverted and corrected contributes nothing. Reliability of bit b of symbol j is rel_i[((5j+b)*5)+4 : (5j+b)*5].
- R5: The decided word is the included vector with the smallest metric. On equal metrics, the lower vector index wins.
- R6: In full mode the competitors are the three next-smallest included vectors, in ascending metric order with the same tie rule. comp_valid_o bit c is high only if competitor c exists, and its metric is at comp_metric_o[9c+8:9c].
- R7: When reduced_i is 1 at the start, only vectors 0..7 are formed (the first three weak bits) and only competitor 0 can be valid.
- R8: A start sampled while idle raises busy_o for exactly the vector count (16 or 8) of cycles. done_o then pulses high for one cycle, in the cycle right after busy_o falls.
- R9: A start_i pulse while busy_o is high is ignored. The run in progress keeps its timing, mode and results.
- R10: If every vector is excluded, dec_valid_o and all comp_valid_o bits are low at done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run (sampled when idle) |
| reduced_i | input | 1 | 1 = 8 vectors and one competitor |
| syn0_i | input | 5 | Base syndrome S0 |
| syn1_i | input | 5 | Base syndrome S1 |
| lrb_sym_i | input | 20 | Symbol index of weak bits 0..3 |
| lrb_bit_i | input | 12 | Bit index of weak bits 0..3 |
| rel_i | input | 775 | Reliability of every bit, held during a run |
| busy_o | output | 1 | Vectors are being processed |
| done_o | output | 1 | One-cycle strobe: results valid |
| dec_valid_o | output | 1 | A decided word exists |
| dec_idx_o | output | 4 | Test-vector index of the decided word |
| dec_metric_o | output | 9 | Metric of the decided word |
| dec_fix_o | output | 1 | Decided word carries a symbol correction |
| dec_pos_o | output | 5 | Corrected symbol position |
| dec_val_o | output | 5 | Correction value XORed into that symbol |
| comp_valid_o | output | 3 | Competitor present flags |
| comp_metric_o | output | 27 | Competitor metrics, ascending |

## Verification
A slip in the per-vector syndrome update or in the closed-form locator first appears as a wrong corrected position or value. It can also show up as a wrong metric for the decided word or for one competitor. All of these are visible in the cycle done_o rises. A count or mode register that is wrong shifts the done strobe away from its exact cycle, or lets a stray competitor flag appear. The bench uses corner inputs to expose a broken ordering in the candidate list: equal metrics, a weak bit cancelled by the correction, and words where no vector survives. These all show at the same done cycle, as a swapped index or a misordered metric pair.

// File: rtl/tvsed_pkg.sv
package tvsed_pkg;

    localparam int SYM_W   = 5;
    localparam int FIELD_N = (1 << SYM_W) - 1;
    localparam int POS_W   = SYM_W;
    localparam int BIT_W   = $clog2(SYM_W);
    localparam int REL_W   = 5;
    localparam int LRB_N   = 4;
    localparam int TV_FULL = 1 << LRB_N;
    localparam int TV_RED  = TV_FULL >> 1;
    localparam int IDX_W   = LRB_N;
    localparam int CW_FULL = 3;
    localparam int CW_RED  = 1;
    localparam int KEEP    = CW_FULL + 1;
    localparam int MET_W   = REL_W + $clog2(LRB_N + SYM_W + 1);
    localparam logic [SYM_W-1:0] POLY_LOW = 5'b00101;

    typedef struct packed {
        logic              ok;
        logic              fix;
        logic [IDX_W-1:0]  idx;
        logic [MET_W-1:0]  metric;
        logic [POS_W-1:0]  pos;
        logic [SYM_W-1:0]  val;
    } cand_t;

    function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] v);
        return {v[SYM_W-2:0], 1'b0} ^ (v[SYM_W-1] ? POLY_LOW : '0);
    endfunction

    function automatic logic [SYM_W-1:0] gf_alog(input int e);
        logic [SYM_W-1:0] v;
        int r;
        v = 1;
        r = e % FIELD_N;
        for (int t = 0; t < FIELD_N; t++)
            if (t < r) v = gf_xtime(v);
        return v;
    endfunction

    function automatic int gf_log(input logic [SYM_W-1:0] v);
        logic [SYM_W-1:0] p;
        int res;
        p = 1;
        res = 0;
        for (int t = 0; t < FIELD_N; t++) begin
            if (p == v) res = t;
            p = gf_xtime(p);
        end
        return res;
    endfunction

endpackage

// File: rtl/tvsed_syndrome.sv
module tvsed_syndrome
    import tvsed_pkg::*;
(
    input  logic [SYM_W-1:0]              s0_i,
    input  logic [SYM_W-1:0]              s1_i,
    input  logic [LRB_N-1:0][POS_W-1:0]   sym_i,
    input  logic [LRB_N-1:0][BIT_W-1:0]   bit_i,
    input  logic [LRB_N-1:0]              flip_i,
    output logic [SYM_W-1:0]              s0_o,
    output logic [SYM_W-1:0]              s1_o
);
    always_comb begin
        s0_o = s0_i;
        s1_o = s1_i;
        for (int k = 0; k < LRB_N; k++) begin
            if (flip_i[k]) begin
                s0_o = s0_o ^ (SYM_W'(1) << bit_i[k]);
                s1_o = s1_o ^ gf_alog(int'(sym_i[k]) + int'(bit_i[k]));
            end
        end
    end
endmodule

// File: rtl/tvsed_corrector.sv
module tvsed_corrector
    import tvsed_pkg::*;
(
    input  logic [SYM_W-1:0] s0_i,
    input  logic [SYM_W-1:0] s1_i,
    output logic             ok_o,
    output logic             fix_o,
    output logic [POS_W-1:0] pos_o,
    output logic [SYM_W-1:0] val_o
);
    int diff;

    always_comb begin
        ok_o  = 1'b0;
        fix_o = 1'b0;
        pos_o = '0;
        val_o = '0;
        diff  = gf_log(s1_i) - gf_log(s0_i);
        if (diff < 0) diff = diff + FIELD_N;
        if (s0_i == '0 && s1_i == '0) begin
            ok_o = 1'b1;
        end else if (s0_i != '0 && s1_i != '0) begin
            ok_o  = 1'b1;
            fix_o = 1'b1;
            val_o = s0_i;
            pos_o = POS_W'(diff);
        end
    end
endmodule

// File: rtl/tvsed_metric.sv
module tvsed_metric
    import tvsed_pkg::*;
(
    input  logic [FIELD_N*SYM_W*REL_W-1:0] rel_i,
    input  logic [LRB_N-1:0][POS_W-1:0]    sym_i,
    input  logic [LRB_N-1:0][BIT_W-1:0]    bit_i,
    input  logic [LRB_N-1:0]               flip_i,
    input  logic                           fix_i,
    input  logic [POS_W-1:0]               pos_i,
    input  logic [SYM_W-1:0]               val_i,
    output logic [MET_W-1:0]               metric_o
);
    logic [SYM_W-1:0] pat;

    always_comb begin
        metric_o = '0;
        pat      = fix_i ? val_i : '0;
        for (int k = 0; k < LRB_N; k++) begin
            if (flip_i[k]) begin
                if (fix_i && sym_i[k] == pos_i)
                    pat = pat ^ (SYM_W'(1) << bit_i[k]);
                else
                    metric_o = metric_o + MET_W'(rel_i[(int'(sym_i[k])*SYM_W + int'(bit_i[k]))*REL_W +: REL_W]);
            end
        end
        if (fix_i) begin
            for (int b = 0; b < SYM_W; b++)
                if (pat[b])
                    metric_o = metric_o + MET_W'(rel_i[(int'(pos_i)*SYM_W + b)*REL_W +: REL_W]);
        end
    end
endmodule

// File: rtl/tvsed_sorter.sv
module tvsed_sorter
    import tvsed_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 load_i,
    input  cand_t                cand_i,
    output cand_t [KEEP-1:0]     list_o
);
    cand_t [KEEP-1:0] list_q, nxt;
    logic  [KEEP-1:0] lt;

    for (genvar s = 0; s < KEEP; s++) begin : g_slot
        assign lt[s] = !list_q[s].ok || (cand_i.metric < list_q[s].metric);
        if (s == 0) begin : g_head
            assign nxt[s] = lt[s] ? cand_i : list_q[s];
        end else begin : g_tail
            assign nxt[s] = !lt[s]     ? list_q[s]   :
                            !lt[s-1]   ? cand_i      : list_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            list_q <= '0;
        else if (load_i && cand_i.ok)
            list_q <= nxt;
    end

    assign list_o = list_q;
endmodule

// File: rtl/tvsed_top.sv
module tvsed_top
    import tvsed_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic                           reduced_i,
    input  logic [SYM_W-1:0]               syn0_i,
    input  logic [SYM_W-1:0]               syn1_i,
    input  logic [LRB_N*POS_W-1:0]         lrb_sym_i,
    input  logic [LRB_N*BIT_W-1:0]         lrb_bit_i,
    input  logic [FIELD_N*SYM_W*REL_W-1:0] rel_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           dec_valid_o,
    output logic [IDX_W-1:0]               dec_idx_o,
    output logic [MET_W-1:0]               dec_metric_o,
    output logic                           dec_fix_o,
    output logic [POS_W-1:0]               dec_pos_o,
    output logic [SYM_W-1:0]               dec_val_o,
    output logic [CW_FULL-1:0]             comp_valid_o,
    output logic [CW_FULL*MET_W-1:0]       comp_metric_o
);
    logic                          busy_q, done_q, red_q, last, launch;
    logic [IDX_W-1:0]              cnt_q;
    logic [SYM_W-1:0]              s0_q, s1_q, tv_s0, tv_s1;
    logic [LRB_N-1:0][POS_W-1:0]   sym_q;
    logic [LRB_N-1:0][BIT_W-1:0]   bit_q;
    cand_t                         cand;
    cand_t [KEEP-1:0]              list;
    int                            cw_act;

    assign launch = start_i && !busy_q;
    assign last   = red_q ? (cnt_q == IDX_W'(TV_RED - 1)) : (cnt_q == IDX_W'(TV_FULL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            red_q  <= 1'b0;
            cnt_q  <= '0;
            s0_q   <= '0;
            s1_q   <= '0;
            sym_q  <= '0;
            bit_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                red_q  <= reduced_i;
                s0_q   <= syn0_i;
                s1_q   <= syn1_i;
                sym_q  <= lrb_sym_i;
                bit_q  <= lrb_bit_i;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    tvsed_syndrome i_syn (
        .s0_i(s0_q), .s1_i(s1_q), .sym_i(sym_q), .bit_i(bit_q),
        .flip_i(cnt_q), .s0_o(tv_s0), .s1_o(tv_s1)
    );

    tvsed_corrector i_cor (
        .s0_i(tv_s0), .s1_i(tv_s1), .ok_o(cand.ok), .fix_o(cand.fix),
        .pos_o(cand.pos), .val_o(cand.val)
    );

    tvsed_metric i_met (
        .rel_i(rel_i), .sym_i(sym_q), .bit_i(bit_q), .flip_i(cnt_q),
        .fix_i(cand.fix), .pos_i(cand.pos), .val_i(cand.val), .metric_o(cand.metric)
    );

    assign cand.idx = cnt_q;

    tvsed_sorter i_sort (
        .clk(clk), .rst(rst), .clear_i(launch), .load_i(busy_q),
        .cand_i(cand), .list_o(list)
    );

    assign cw_act       = red_q ? CW_RED : CW_FULL;
    assign busy_o       = busy_q;
    assign done_o       = done_q;
    assign dec_valid_o  = list[0].ok;
    assign dec_idx_o    = list[0].idx;
    assign dec_metric_o = list[0].metric;
    assign dec_fix_o    = list[0].fix;
    assign dec_pos_o    = list[0].pos;
    assign dec_val_o    = list[0].val;

    for (genvar c = 0; c < CW_FULL; c++) begin : g_comp
        assign comp_valid_o[c]                  = list[c+1].ok && (c < cw_act);
        assign comp_metric_o[c*MET_W +: MET_W]  = list[c+1].metric;
    end
endmodule

// File: rtl/tvsed_chk.sv
module tvsed_chk
    import tvsed_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     dec_valid_o,
    input logic                     dec_fix_o,
    input logic [POS_W-1:0]         dec_pos_o,
    input logic [SYM_W-1:0]         dec_val_o,
    input logic [MET_W-1:0]         dec_metric_o,
    input logic [CW_FULL-1:0]       comp_valid_o,
    input logic [CW_FULL*MET_W-1:0] comp_metric_o
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_len <= 0;
        else                run_len <= run_len + 1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !dec_valid_o && comp_valid_o == '0));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_len_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && (run_len == TV_FULL || run_len == TV_RED)));

    p_busy_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> run_len < TV_FULL);

    p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    p_clean_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && dec_valid_o && !dec_fix_o) |-> (dec_pos_o == '0 && dec_val_o == '0));

    p_fix_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && dec_valid_o && dec_fix_o) |-> (dec_val_o != '0));

    p_dec_min_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && comp_valid_o[0]) |-> (dec_metric_o <= comp_metric_o[MET_W-1:0]));

    p_comp_needs_dec_r10: assert property (@(posedge clk) disable iff (rst)
        comp_valid_o[0] |-> dec_valid_o);

    for (genvar c = 1; c < CW_FULL; c++) begin : g_ord
        p_comp_order_r6: assert property (@(posedge clk) disable iff (rst)
            comp_valid_o[c] |-> (comp_valid_o[c-1] &&
                comp_metric_o[(c-1)*MET_W +: MET_W] <= comp_metric_o[c*MET_W +: MET_W]));
    end
endmodule

bind tvsed_top tvsed_chk i_tvsed_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
    .dec_valid_o(dec_valid_o), .dec_fix_o(dec_fix_o), .dec_pos_o(dec_pos_o),
    .dec_val_o(dec_val_o), .dec_metric_o(dec_metric_o),
    .comp_valid_o(comp_valid_o), .comp_metric_o(comp_metric_o)
);

// File: tb/test_tvsed_top.sv
module test_tvsed_top;
    import tvsed_pkg::*;

    logic                           clk = 1'b0;
    logic                           rst = 1'b1;
    logic                           start_i = 1'b0;
    logic                           reduced_i = 1'b0;
    logic [SYM_W-1:0]               syn0_i = '0;
    logic [SYM_W-1:0]               syn1_i = '0;
    logic [LRB_N*POS_W-1:0]         lrb_sym_i = '0;
    logic [LRB_N*BIT_W-1:0]         lrb_bit_i = '0;
    logic [FIELD_N*SYM_W*REL_W-1:0] rel_i = '0;
    logic                           busy_o, done_o, dec_valid_o, dec_fix_o;
    logic [IDX_W-1:0]               dec_idx_o;
    logic [MET_W-1:0]               dec_metric_o;
    logic [POS_W-1:0]               dec_pos_o;
    logic [SYM_W-1:0]               dec_val_o;
    logic [CW_FULL-1:0]             comp_valid_o;
    logic [CW_FULL*MET_W-1:0]       comp_metric_o;

    int checks = 0;
    int fails  = 0;
    int rel_a [FIELD_N][SYM_W];

    always #10 clk = ~clk;

    tvsed_top i_tvsed_top (
        .clk(clk), .rst(rst), .start_i(start_i), .reduced_i(reduced_i),
        .syn0_i(syn0_i), .syn1_i(syn1_i), .lrb_sym_i(lrb_sym_i), .lrb_bit_i(lrb_bit_i),
        .rel_i(rel_i), .busy_o(busy_o), .done_o(done_o), .dec_valid_o(dec_valid_o),
        .dec_idx_o(dec_idx_o), .dec_metric_o(dec_metric_o), .dec_fix_o(dec_fix_o),
        .dec_pos_o(dec_pos_o), .dec_val_o(dec_val_o), .comp_valid_o(comp_valid_o),
        .comp_metric_o(comp_metric_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gmul(input int a, input int b);
        int r = 0;
        int x = a;
        for (int t = 0; t < SYM_W; t++) begin
            if ((b >> t) & 1) r = r ^ x;
            x = x << 1;
            if (x & 32) x = x ^ 37;
        end
        return r;
    endfunction

    function automatic int apow(input int e);
        int v = 1;
        for (int t = 0; t < e; t++) v = gmul(v, 2);
        return v;
    endfunction

    task automatic fill_rel(input int seed);
        for (int s = 0; s < FIELD_N; s++)
            for (int b = 0; b < SYM_W; b++)
                rel_a[s][b] = 2 + ((s * 11 + b * 7 + seed) % 29);
    endtask

    task automatic pack_rel();
        for (int s = 0; s < FIELD_N; s++)
            for (int b = 0; b < SYM_W; b++)
                rel_i[(s * SYM_W + b) * REL_W +: REL_W] = REL_W'(rel_a[s][b]);
    endtask

    task automatic run_case(input string tag, input int s0, input int s1,
                            input int sy [LRB_N], input int bi [LRB_N],
                            input bit red, input bit poke);
        int tv = red ? TV_RED : TV_FULL;
        int ncw = red ? CW_RED : CW_FULL;
        bit e_ok [TV_FULL];
        bit e_fix [TV_FULL];
        int e_pos [TV_FULL];
        int e_val [TV_FULL];
        int e_met [TV_FULL];
        bit used [TV_FULL];
        int rank [KEEP];
        bit d [FIELD_N][SYM_W];
        for (int i = 0; i < tv; i++) begin
            int a0 = s0;
            int a1 = s1;
            for (int k = 0; k < LRB_N; k++)
                if ((i >> k) & 1) begin
                    a0 = a0 ^ (1 << bi[k]);
                    a1 = a1 ^ gmul(1 << bi[k], apow(sy[k]));
                end
            e_ok[i] = 1; e_fix[i] = 0; e_pos[i] = 0; e_val[i] = 0; used[i] = 0;
            if ((a0 == 0) != (a1 == 0)) e_ok[i] = 0;
            else if (a0 != 0) begin
                e_fix[i] = 1; e_val[i] = a0;
                for (int j = 0; j < FIELD_N; j++)
                    if (gmul(a0, apow(j)) == a1) e_pos[i] = j;
            end
            for (int s = 0; s < FIELD_N; s++)
                for (int b = 0; b < SYM_W; b++) d[s][b] = 0;
            for (int k = 0; k < LRB_N; k++)
                if ((i >> k) & 1) d[sy[k]][bi[k]] = !d[sy[k]][bi[k]];
            if (e_fix[i])
                for (int b = 0; b < SYM_W; b++)
                    if ((e_val[i] >> b) & 1) d[e_pos[i]][b] = !d[e_pos[i]][b];
            e_met[i] = 0;
            for (int s = 0; s < FIELD_N; s++)
                for (int b = 0; b < SYM_W; b++)
                    if (d[s][b]) e_met[i] += rel_a[s][b];
        end
        for (int r = 0; r < KEEP; r++) begin
            int best = -1;
            for (int i = 0; i < tv; i++)
                if (e_ok[i] && !used[i] && (best < 0 || e_met[i] < e_met[best])) best = i;
            rank[r] = best;
            if (best >= 0) used[best] = 1;
        end

        pack_rel();
        @(negedge clk);
        syn0_i = SYM_W'(s0);
        syn1_i = SYM_W'(s1);
        for (int k = 0; k < LRB_N; k++) begin
            lrb_sym_i[k*POS_W +: POS_W] = POS_W'(sy[k]);
            lrb_bit_i[k*BIT_W +: BIT_W] = BIT_W'(bi[k]);
        end
        reduced_i = red;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk("R8", {tag, " busy after start"}, int'(busy_o), 1);
        for (int c = 1; c <= tv; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && c == 2) begin
                start_i = 1'b1;
                syn0_i = syn0_i ^ 5'h11;
                reduced_i = !red;
            end else start_i = 1'b0;
            if (c == tv - 1) chk(poke ? "R9" : "R8", {tag, " done early"}, int'(done_o), 0);
            if (c == tv) begin
                chk(poke ? "R9" : "R8", {tag, " done on time"}, int'(done_o), 1);
                chk("R8", {tag, " busy cleared"}, int'(busy_o), 0);
            end
        end
        chk("R5", {tag, " dec_valid"}, int'(dec_valid_o), int'(rank[0] >= 0));
        if (rank[0] >= 0) begin
            chk("R5", {tag, " dec_idx"}, int'(dec_idx_o), rank[0]);
            chk("R4", {tag, " dec_metric"}, int'(dec_metric_o), e_met[rank[0]]);
            chk("R3", {tag, " dec_fix"}, int'(dec_fix_o), int'(e_fix[rank[0]]));
            chk("R3", {tag, " dec_pos"}, int'(dec_pos_o), e_pos[rank[0]]);
            chk("R3", {tag, " dec_val"}, int'(dec_val_o), e_val[rank[0]]);
        end
        for (int c = 0; c < CW_FULL; c++) begin
            int ev = (c < ncw) && (rank[c+1] >= 0);
            chk(red ? "R7" : "R6", {tag, " comp_valid"}, int'(comp_valid_o[c]), ev);
            if (ev)
                chk("R6", {tag, " comp_metric"},
                    int'(comp_metric_o[c*MET_W +: MET_W]), e_met[rank[c+1]]);
        end
        @(negedge clk);
        chk("R8", {tag, " done one cycle"}, int'(done_o), 0);
        reduced_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "done after reset", int'(done_o), 0);
        chk("R1", "dec_valid after reset", int'(dec_valid_o), 0);
        chk("R1", "comp_valid after reset", int'(comp_valid_o), 0);
    endtask

    task automatic t_full_mixed();
        int sy [LRB_N] = '{3, 17, 29, 8};
        int bi [LRB_N] = '{0, 4, 2, 1};
        fill_rel(5);
        run_case("R2 full mixed", 5'h13, 5'h0A, sy, bi, 1'b0, 1'b0);
    endtask

    task automatic t_clean_word();
        int sy [LRB_N] = '{1, 2, 30, 12};
        int bi [LRB_N] = '{3, 3, 0, 4};
        fill_rel(13);
        run_case("R3 clean word", 0, 0, sy, bi, 1'b0, 1'b0);
        chk("R3", "clean word picks vector 0", int'(dec_idx_o), 0);
        chk("R4", "clean word metric zero", int'(dec_metric_o), 0);
    endtask

    task automatic t_overlap_tie();
        int sy [LRB_N] = '{6, 20, 14, 27};
        int bi [LRB_N] = '{2, 1, 3, 0};
        fill_rel(21);
        rel_a[6][2] = 1;
        run_case("R4 overlap tie", 4, gmul(4, apow(6)), sy, bi, 1'b0, 1'b0);
        chk("R5", "tie keeps lowest index", int'(dec_idx_o), 0);
        chk("R4", "cancelled bit metric", int'(dec_metric_o), 1);
    endtask

    task automatic t_fail_exclude();
        int sy [LRB_N] = '{9, 4, 22, 15};
        int bi [LRB_N] = '{1, 0, 4, 2};
        fill_rel(2);
        run_case("R3 one zero syndrome", 7, 0, sy, bi, 1'b0, 1'b0);
    endtask

    task automatic t_all_fail();
        int sy [LRB_N] = '{0, 0, 0, 0};
        int bi [LRB_N] = '{0, 0, 0, 0};
        fill_rel(9);
        run_case("R10 all excluded", 1, 0, sy, bi, 1'b0, 1'b0);
        chk("R10", "no decided word", int'(dec_valid_o), 0);
        chk("R10", "no competitors", int'(comp_valid_o), 0);
    endtask

    task automatic t_reduced();
        int sy [LRB_N] = '{5, 18, 25, 11};
        int bi [LRB_N] = '{4, 2, 0, 3};
        fill_rel(17);
        run_case("R7 reduced", 5'h1B, 5'h06, sy, bi, 1'b1, 1'b0);
    endtask

    task automatic t_restart_ignored();
        int sy [LRB_N] = '{7, 13, 2, 23};
        int bi [LRB_N] = '{1, 3, 4, 0};
        fill_rel(27);
        run_case("R9 start while busy", 5'h0E, 5'h15, sy, bi, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_mixed();
        t_clean_word();
        t_overlap_tie();
        t_fail_exclude();
        t_all_fail();
        t_reduced();
        t_restart_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule